// File: doc/BRIEF.md
# Dual-Rail / One-of-Four Radix Bridge

This block converts between two return-to-zero balanced codes. The mixing path takes two dual-rail bits and produces one 1-of-4 symbol. The splitting path takes one 1-of-4 symbol and produces two dual-rail bits. On every wire group, an all-low word is the spacer, and consecutive data words must be separated by one. The two paths are independent of each other. They share a clock, a synchronous reset and one sticky error flag.

Each output is registered, so a change shows one clock after the input that causes it. The mixer has state. It raises a data symbol only once both dual-rail inputs carry data. It keeps that symbol until both inputs have gone back to spacer. Because of this, a half-arrived or half-withdrawn word never shows at the output.

The codes carry their own validity, so there are no valid or ready wires. There is also no back-pressure. The sender controls the pace by inserting spacers, and the block accepts a new word on any clock. A legal but unexpected word, such as new data that arrives without a spacer, is ignored, and the output holds.

Top module: `rtb_radix_bridge`

## Requirements
- R1: Dual-rail encoding is 01 for logic 0, 10 for logic 1 and 00 for spacer. The high input is the MSB of the 2-bit value v. When both inputs carry data and the mixer output is spacer, the mixer output one clock later has only bit v set: 0001, 0010, 0100 or 1000.
- R2: When only one dual-rail input carries data, the mixer output stays spacer.
- R3: A data symbol on the mixer output holds unchanged while either input is still non-spacer. This includes the case where the inputs change to other legal data.
- R4: One clock after both dual-rail inputs are spacer, the mixer output is spacer.
- R5: One clock after the splitter input holds a single high wire at position v, the splitter outputs carry v. The high output carries the MSB and the low output carries the LSB, each as a dual-rail bit.
- R6: One clock after the splitter input is 0000, both splitter outputs are 00.
- R7: An illegal code sets the error flag on the next clock. An illegal code is 11 on either dual-rail input, or two or more high wires on the 1-of-4 input.
- R8: The error flag stays set until reset. While it is set, every output is spacer, whatever the inputs are.
- R9: A synchronous active-high reset makes every output spacer and clears the error flag on the next clock.
- R10: The mixer output never has more than one high wire, and neither splitter output is ever 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mix_in_hi | input | 2 | Dual-rail MSB into the mixer |
| mix_in_lo | input | 2 | Dual-rail LSB into the mixer |
| mix_out | output | 4 | 1-of-4 symbol from the mixer |
| spl_in | input | 4 | 1-of-4 symbol into the splitter |
| spl_out_hi | output | 2 | Dual-rail MSB from the splitter |
| spl_out_lo | output | 2 | Dual-rail LSB from the splitter |
| code_err | output | 1 | Sticky illegal-code flag |

## Verification
All four values pass through both paths. Each data word is separated by a spacer, which shows that the encoding table and the bit order are right. Some words arrive one input at a time and are withdrawn one input at a time. These separate a mixer that waits for both inputs from one that fires or releases on only one. A word that changes without a spacer shows that a held symbol is not overwritten. Illegal codes are injected on each of the three input groups, including one while a symbol is held, followed by clean traffic. These show that the flag is sticky, that it silences the outputs, and that only reset clears it.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
  localparam int DR_W = 2;
  localparam int Q_W  = 4;
  localparam int SEL_W = $clog2(Q_W);

  typedef logic [DR_W-1:0] dr_t;
  typedef logic [Q_W-1:0]  quad_t;

  localparam dr_t   DR_SPACER = 2'b00;
  localparam dr_t   DR_ZERO   = 2'b01;
  localparam dr_t   DR_ONE    = 2'b10;
  localparam quad_t Q_SPACER  = '0;
endpackage

// File: rtl/rtb_dr_class.sv
module rtb_dr_class
  import rtb_pkg::*;
(
  input  dr_t  rail,
  output logic is_data,
  output logic is_spacer,
  output logic is_bad,
  output logic bit_val
);
  always_comb begin
    is_spacer = (rail == DR_SPACER);
    is_data   = (rail == DR_ZERO) || (rail == DR_ONE);
    is_bad    = !is_spacer && !is_data;
    bit_val   = (rail == DR_ONE);
  end
endmodule

// File: rtl/rtb_mixer.sv
module rtb_mixer
  import rtb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  kill,
  input  logic  hi_data,
  input  logic  lo_data,
  input  logic  hi_spacer,
  input  logic  lo_spacer,
  input  logic  hi_bit,
  input  logic  lo_bit,
  output quad_t sym
);
  logic [SEL_W-1:0] sel;
  quad_t            sym_q;

  assign sel = {hi_bit, lo_bit};
  assign sym = sym_q;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      sym_q <= Q_SPACER;
    end else if (sym_q == Q_SPACER) begin
      if (hi_data && lo_data) sym_q <= quad_t'(1) << sel;
    end else if (hi_spacer && lo_spacer) begin
      sym_q <= Q_SPACER;
    end
  end
endmodule

// File: rtl/rtb_splitter.sv
module rtb_splitter
  import rtb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  kill,
  input  quad_t sym,
  output logic  bad,
  output dr_t   out_hi,
  output dr_t   out_lo
);
  dr_t hi_q, lo_q;

  assign bad    = $countones(sym) > 1;
  assign out_hi = hi_q;
  assign out_lo = lo_q;

  always_ff @(posedge clk) begin
    if (rst || kill || sym == Q_SPACER) begin
      hi_q <= DR_SPACER;
      lo_q <= DR_SPACER;
    end else begin
      hi_q <= (sym[3] | sym[2]) ? DR_ONE : DR_ZERO;
      lo_q <= (sym[3] | sym[1]) ? DR_ONE : DR_ZERO;
    end
  end
endmodule

// File: rtl/rtb_radix_bridge.sv
module rtb_radix_bridge
  import rtb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mix_in_hi,
  input  logic [1:0] mix_in_lo,
  output logic [3:0] mix_out,
  input  logic [3:0] spl_in,
  output logic [1:0] spl_out_hi,
  output logic [1:0] spl_out_lo,
  output logic       code_err
);
  localparam int NRAIL = 2;

  dr_t  rails [NRAIL];
  logic r_data [NRAIL];
  logic r_sp   [NRAIL];
  logic r_bad  [NRAIL];
  logic r_bit  [NRAIL];
  logic spl_bad, bad_any, err_q, kill;

  assign rails[0] = mix_in_lo;
  assign rails[1] = mix_in_hi;

  for (genvar g = 0; g < NRAIL; g++) begin : g_rail
    rtb_dr_class u_cls (
      .rail      (rails[g]),
      .is_data   (r_data[g]),
      .is_spacer (r_sp[g]),
      .is_bad    (r_bad[g]),
      .bit_val   (r_bit[g])
    );
  end

  assign bad_any = r_bad[0] | r_bad[1] | spl_bad;
  assign kill    = err_q | bad_any;

  always_ff @(posedge clk) begin
    if (rst)          err_q <= 1'b0;
    else if (bad_any) err_q <= 1'b1;
  end

  rtb_mixer u_mix (
    .clk       (clk),
    .rst       (rst),
    .kill      (kill),
    .hi_data   (r_data[1]),
    .lo_data   (r_data[0]),
    .hi_spacer (r_sp[1]),
    .lo_spacer (r_sp[0]),
    .hi_bit    (r_bit[1]),
    .lo_bit    (r_bit[0]),
    .sym       (mix_out)
  );

  rtb_splitter u_spl (
    .clk    (clk),
    .rst    (rst),
    .kill   (kill),
    .sym    (spl_in),
    .bad    (spl_bad),
    .out_hi (spl_out_hi),
    .out_lo (spl_out_lo)
  );

  assign code_err = err_q;
endmodule

// File: rtl/rtb_radix_checker.sv
module rtb_radix_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mix_in_hi,
  input logic [1:0] mix_in_lo,
  input logic [3:0] mix_out,
  input logic [3:0] spl_in,
  input logic [1:0] spl_out_hi,
  input logic [1:0] spl_out_lo,
  input logic       code_err
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  a_r10_legal_outputs: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mix_out) && spl_out_hi != 2'b11 && spl_out_lo != 2'b11);

  a_r9_reset_clears: assert property (@(posedge clk)
    started && $past(rst) |-> mix_out == 4'b0 && spl_out_hi == 2'b0 &&
                              spl_out_lo == 2'b0 && !code_err);

  a_r2_needs_both: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) && $past(mix_out) == 4'b0 && mix_out != 4'b0
      |-> $past((^mix_in_hi) && (^mix_in_lo)));

  a_r4_release_on_spacer: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) && $past(mix_out) != 4'b0 && mix_out == 4'b0
      |-> $past(mix_in_hi == 2'b0 && mix_in_lo == 2'b0) || code_err);

  a_r3_hold_symbol: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) && $past(mix_out) != 4'b0 &&
    !$past(mix_in_hi == 2'b0 && mix_in_lo == 2'b0) && !code_err
      |-> $stable(mix_out));

  a_r6_split_spacer: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) && $past(spl_in) == 4'b0
      |-> spl_out_hi == 2'b0 && spl_out_lo == 2'b0);

  a_r7_flag_raised: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) &&
    $past(mix_in_hi == 2'b11 || mix_in_lo == 2'b11 || $countones(spl_in) > 1)
      |-> code_err);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    started && !$past(rst) && $past(code_err) |-> code_err);

  a_r8_silenced: assert property (@(posedge clk) disable iff (rst)
    code_err |-> mix_out == 4'b0 && spl_out_hi == 2'b0 && spl_out_lo == 2'b0);
endmodule

bind rtb_radix_bridge rtb_radix_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .mix_in_hi  (mix_in_hi),
  .mix_in_lo  (mix_in_lo),
  .mix_out    (mix_out),
  .spl_in     (spl_in),
  .spl_out_hi (spl_out_hi),
  .spl_out_lo (spl_out_lo),
  .code_err   (code_err)
);

// File: tb/rtb_radix_bridge_bench.sv
module rtb_radix_bridge_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mix_in_hi = 2'b0, mix_in_lo = 2'b0;
  logic [3:0] spl_in = 4'b0;
  logic [3:0] mix_out;
  logic [1:0] spl_out_hi, spl_out_lo;
  logic       code_err;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  rtb_radix_bridge u_rtb_radix_bridge (
    .clk(clk), .rst(rst), .mix_in_hi(mix_in_hi), .mix_in_lo(mix_in_lo),
    .mix_out(mix_out), .spl_in(spl_in), .spl_out_hi(spl_out_hi),
    .spl_out_lo(spl_out_lo), .code_err(code_err)
  );

  // {hi, lo, spl_in, expected mix_out, expected spl hi, expected spl lo}
  localparam int NV = 15;
  localparam logic [15:0] VEC [NV] = '{
    16'b00_00_0000_0000_00_00,
    16'b01_00_0001_0000_01_01,
    16'b01_01_0000_0001_00_00,
    16'b00_01_0010_0001_01_10,
    16'b00_00_0000_0000_00_00,
    16'b10_01_0100_0100_10_01,
    16'b00_00_0000_0000_00_00,
    16'b10_10_1000_1000_10_10,
    16'b01_10_0000_1000_00_00,
    16'b00_00_0000_0000_00_00,
    16'b01_10_0000_0010_00_00,
    16'b00_10_0000_0010_00_00,
    16'b00_00_0000_0000_00_00,
    16'b00_10_0000_0000_00_00,
    16'b00_00_0000_0000_00_00
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] h, input logic [1:0] l, input logic [3:0] s);
    mix_in_hi = h; mix_in_lo = l; spl_in = s;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; step(2'b00, 2'b00, 4'b0000);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    // R9: reset with live inputs on every group
    step(2'b01, 2'b01, 4'b0010);
    chk("R9 reset outputs", {mix_out, spl_out_hi, spl_out_lo}, 8'h00);
    chk("R9 reset flag", {7'b0, code_err}, 8'h00);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15:14], VEC[i][13:12], VEC[i][11:8]);
      chk($sformatf("R1 R2 R3 R4 mixer row %0d", i), {4'b0, mix_out}, {4'b0, VEC[i][7:4]});
      chk($sformatf("R5 R6 splitter row %0d", i), {4'b0, spl_out_hi, spl_out_lo}, {4'b0, VEC[i][3:0]});
      chk($sformatf("R10 single wire row %0d", i), {7'b0, $countones(mix_out) <= 1}, 8'h01);
    end
    chk("R7 no flag on legal traffic", {7'b0, code_err}, 8'h00);

    // R7/R8: bad dual-rail high input, then clean traffic stays silenced
    step(2'b11, 2'b01, 4'b0000);
    chk("R7 flag from high rail", {7'b0, code_err}, 8'h01);
    step(2'b01, 2'b01, 4'b0001);
    chk("R8 silenced outputs", {mix_out, spl_out_hi, spl_out_lo}, 8'h00);
    step(2'b00, 2'b00, 4'b0000);
    step(2'b10, 2'b10, 4'b1000);
    chk("R8 flag sticky", {7'b0, code_err}, 8'h01);
    chk("R8 still silenced", {mix_out, spl_out_hi, spl_out_lo}, 8'h00);
    do_reset();
    chk("R9 flag cleared", {7'b0, code_err}, 8'h00);

    // R9: reset while a symbol is held
    step(2'b10, 2'b10, 4'b0000);
    chk("R1 value 3 before reset", {4'b0, mix_out}, 8'h08);
    rst = 1'b1; step(2'b10, 2'b10, 4'b0100);
    chk("R9 reset drops held symbol", {mix_out, spl_out_hi, spl_out_lo}, 8'h00);
    rst = 1'b0; step(2'b00, 2'b00, 4'b0000);

    // R7: splitter multi-hot
    step(2'b00, 2'b00, 4'b0110);
    chk("R7 flag from splitter", {7'b0, code_err}, 8'h01);
    chk("R7 splitter spacer on bad", {4'b0, spl_out_hi, spl_out_lo}, 8'h00);
    do_reset();

    // R8: bad low rail while mixer holds a symbol
    step(2'b01, 2'b10, 4'b0000);
    chk("R1 value 1", {4'b0, mix_out}, 8'h02);
    step(2'b01, 2'b11, 4'b0000);
    chk("R8 error forces spacer", {4'b0, mix_out}, 8'h00);
    chk("R7 flag from low rail", {7'b0, code_err}, 8'h01);
    do_reset();

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end
endmodule